// File: doc/BRIEF.md
# Reset Source Controller with Sticky Cause Flags

This block collects every request that may reset the chip and turns each accepted one into a single system reset pulse of fixed length. Requests come from the power-on reset, the power-down and brown-out supply detectors, the external reset pin, a processor lockup indication, the interrupt controller's system-reset request, two watchdogs, a debug/memory-fault request and a keyed software write. Each input other than power-on is a one-cycle synchronous pulse. The comparators behind the detectors sit outside the block, so their enables and threshold codes leave it as plain registered outputs.

Software reads and clears a sticky cause register over a simple word-addressed register bus. The same bus holds the configuration for the two supply detectors and the lockup reset enable, and it takes the software reset key. The block lives in the always-on domain. Only the power-on reset (`rst`) clears its state. The system reset it drives does not clear the block itself.

Register map (word address on `bus_addr_i`): 0 cause flags, 1 power-down control, 2 brown-out control, 3 lockup control, 4 software reset key. Every other address reads zero and ignores writes.

Top module: `rstsrc_ctrl`

## Requirements
- R1: While `rst` is high and after it falls, the cause register reads exactly 0x200 (only bit 9 set). The power-down control register reads 0x1 (enabled, level 0). The brown-out control register reads 0x0 (enabled, level 0). The lockup control register reads 0x2 (enabled).
- R2: An accepted request sets one cause bit. Bit 0 is the interrupt-controller request, bit 1 lockup, bit 2 window watchdog, bit 4 independent watchdog, bit 5 software key, bit 8 power-down trip, bit 10 brown-out trip, bit 11 reset pin and bit 12 debug/memory fault. Bits 3, 6, 7 and 13 to 31 always read 0.
- R3: A write to address 0 clears each cause bit whose data bit is 1 and leaves every bit whose data bit is 0 unchanged.
- R4: If a cause bit is cleared and set again in the same cycle, it ends up set.
- R5: A software reset is accepted only when a write to address 4 carries exactly 0x5C5CAABB. Any other value has no effect. Address 4 reads 0.
- R6: Bit 1 of address 3 enables lockup reset. While that bit is 0, `lockup_i` neither asserts `sys_rst_o` nor sets cause bit 1.
- R7: At address 1, bit 0 enables the power-down detector (`pdr_en_o`) and bits 2:1 give its level (`pdr_level_o`). While the detector is disabled, `pdr_trip_i` is ignored.
- R8: At address 2, bit 0 disables the brown-out detector when set (`bor_en_o` is its inverse) and bits 3:2 give its level (`bor_level_o`). Bit 1 reads 0. While the detector is disabled, `bor_trip_i` is ignored.
- R9: An accepted request in a cycle drives `sys_rst_o` high from the next cycle for 16 cycles. A new request restarts the count. The last cycle of `rst` counts as a request.
- R10: `sys_rst_o` changes neither the cause flags nor the configuration. Writes to unmapped addresses change nothing.
- R11: `bus_rdata_o` shows, one cycle later, the register selected by `bus_addr_i`, taken from its value before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Register word address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Registered read data |
| irq_sysreq_i | input | 1 | Interrupt-controller system reset request pulse |
| lockup_i | input | 1 | Processor lockup pulse |
| wwdg_i | input | 1 | Window watchdog expiry pulse |
| iwdg_i | input | 1 | Independent watchdog expiry pulse |
| pdr_trip_i | input | 1 | Power-down comparator trip pulse |
| bor_trip_i | input | 1 | Brown-out comparator trip pulse |
| pin_rst_i | input | 1 | Synchronised external reset pin pulse |
| dbg_fault_i | input | 1 | Debug/memory fault reset request pulse |
| sys_rst_o | output | 1 | System reset, active high |
| pdr_en_o | output | 1 | Power-down detector enable |
| pdr_level_o | output | LVL_W | Power-down threshold code, 0 lowest |
| bor_en_o | output | 1 | Brown-out detector enable, active high |
| bor_level_o | output | LVL_W | Brown-out threshold code, 0 lowest |

## Verification
A fault in the cause register shows on `bus_rdata_o` one cycle after address 0 is presented, so the bench keeps that address selected during most stimulus and sees a lost, extra or uncleared bit within a cycle of the event. A gate that wrongly accepts a disabled detector or lockup shows twice: a cause bit appears, and `sys_rst_o` rises in the next cycle. A wrong stretch count shows as a falling edge of `sys_rst_o` early or late against the 16-cycle window. Configuration faults appear on the detector outputs in the cycle after the write.

// File: rtl/rstsrc_pkg.sv
package rstsrc_pkg;

  localparam int unsigned CAUSE_W = 13;
  localparam int unsigned LVL_W   = 2;

  // cause bit positions: decoded by software, so fixed
  localparam int unsigned C_IRQREQ = 0;
  localparam int unsigned C_LOCKUP = 1;
  localparam int unsigned C_WWDG   = 2;
  localparam int unsigned C_IWDG   = 4;
  localparam int unsigned C_SOFT   = 5;
  localparam int unsigned C_PDR    = 8;
  localparam int unsigned C_POR    = 9;
  localparam int unsigned C_BOR    = 10;
  localparam int unsigned C_PIN    = 11;
  localparam int unsigned C_DBGF   = 12;

  // register word addresses
  localparam int unsigned A_CAUSE = 0;
  localparam int unsigned A_PDR   = 1;
  localparam int unsigned A_BOR   = 2;
  localparam int unsigned A_LKUP  = 3;
  localparam int unsigned A_SOFT  = 4;

  localparam logic [31:0] SOFT_KEY = 32'h5C5C_AABB;

  typedef struct packed {
    logic             pdr_en;
    logic [LVL_W-1:0] pdr_lvl;
    logic             bor_en;
    logic [LVL_W-1:0] bor_lvl;
    logic             lk_en;
  } cfg_t;

  localparam cfg_t CFG_DEFAULT = '{pdr_en: 1'b1, pdr_lvl: '0,
                                   bor_en: 1'b1, bor_lvl: '0,
                                   lk_en: 1'b1};

  function automatic logic [CAUSE_W-1:0] cause_valid();
    logic [CAUSE_W-1:0] m;
    m = '0;
    m[C_IRQREQ] = 1'b1;
    m[C_LOCKUP] = 1'b1;
    m[C_WWDG]   = 1'b1;
    m[C_IWDG]   = 1'b1;
    m[C_SOFT]   = 1'b1;
    m[C_PDR]    = 1'b1;
    m[C_POR]    = 1'b1;
    m[C_BOR]    = 1'b1;
    m[C_PIN]    = 1'b1;
    m[C_DBGF]   = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/rstsrc_cfg.sv
module rstsrc_cfg
  import rstsrc_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY = DATA_W'(SOFT_KEY)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output cfg_t              cfg_o,
  output logic              soft_req_o
);

  cfg_t cfg_q;
  logic wr_pdr, wr_bor, wr_lkup;

  assign wr_pdr  = we_i && (addr_i == ADDR_W'(A_PDR));
  assign wr_bor  = we_i && (addr_i == ADDR_W'(A_BOR));
  assign wr_lkup = we_i && (addr_i == ADDR_W'(A_LKUP));

  // the full data word must match; a near miss does nothing
  assign soft_req_o = we_i && (addr_i == ADDR_W'(A_SOFT)) && (wdata_i == KEY);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= CFG_DEFAULT;
    end else begin
      if (wr_pdr) begin
        cfg_q.pdr_en  <= wdata_i[0];
        cfg_q.pdr_lvl <= wdata_i[LVL_W:1];
      end
      if (wr_bor) begin
        // register bit 0 is a disable; store the enable sense
        cfg_q.bor_en  <= ~wdata_i[0];
        cfg_q.bor_lvl <= wdata_i[LVL_W+1:2];
      end
      if (wr_lkup) begin
        cfg_q.lk_en <= wdata_i[1];
      end
    end
  end

  assign cfg_o = cfg_q;

endmodule

// File: rtl/rstsrc_flags.sv
module rstsrc_flags #(
  parameter int unsigned W = 13,
  parameter logic [W-1:0] VALID = '1,
  parameter int unsigned POR_BIT = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flags_o
);

  localparam logic [W-1:0] POR_ONLY = W'(1) << POR_BIT;

  logic [W-1:0] flags_q;

  // set is applied after clear so a same-cycle event is never lost
  always_ff @(posedge clk) begin
    if (rst) flags_q <= POR_ONLY;
    else     flags_q <= ((flags_q & ~clr_i) | set_i) & VALID;
  end

  assign flags_o = flags_q;

endmodule

// File: rtl/rstsrc_stretch.sv
module rstsrc_stretch #(
  parameter int unsigned HOLD_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_i,
  output logic rst_o
);

  localparam int unsigned CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(HOLD_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             out_q;

  always_ff @(posedge clk) begin
    if (rst || trig_i) begin
      cnt_q <= RELOAD;
      out_q <= 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      out_q <= 1'b1;
    end else begin
      out_q <= 1'b0;
    end
  end

  assign rst_o = out_q;

endmodule

// File: rtl/rstsrc_ctrl.sv
module rstsrc_ctrl
  import rstsrc_pkg::*;
#(
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned HOLD_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              irq_sysreq_i,
  input  logic              lockup_i,
  input  logic              wwdg_i,
  input  logic              iwdg_i,
  input  logic              pdr_trip_i,
  input  logic              bor_trip_i,
  input  logic              pin_rst_i,
  input  logic              dbg_fault_i,
  output logic              sys_rst_o,
  output logic              pdr_en_o,
  output logic [LVL_W-1:0]  pdr_level_o,
  output logic              bor_en_o,
  output logic [LVL_W-1:0]  bor_level_o
);

  localparam logic [CAUSE_W-1:0] VALID = cause_valid();

  cfg_t               cfg;
  logic               soft_req;
  logic               lk_en;
  logic               req_any;
  logic [CAUSE_W-1:0] req_vec;
  logic [CAUSE_W-1:0] clr_vec;
  logic [CAUSE_W-1:0] cause_q;
  logic [DATA_W-1:0]  rdata_q;

  rstsrc_cfg #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) cfg_i (
    .clk        (clk),
    .rst        (rst),
    .we_i       (bus_we_i),
    .addr_i     (bus_addr_i),
    .wdata_i    (bus_wdata_i),
    .cfg_o      (cfg),
    .soft_req_o (soft_req)
  );

  assign lk_en = cfg.lk_en;

  // gate each source by its enable and place it on its cause bit
  always_comb begin
    req_vec           = '0;
    req_vec[C_IRQREQ] = irq_sysreq_i;
    req_vec[C_LOCKUP] = lockup_i & lk_en;
    req_vec[C_WWDG]   = wwdg_i;
    req_vec[C_IWDG]   = iwdg_i;
    req_vec[C_SOFT]   = soft_req;
    req_vec[C_PDR]    = pdr_trip_i & cfg.pdr_en;
    req_vec[C_BOR]    = bor_trip_i & cfg.bor_en;
    req_vec[C_PIN]    = pin_rst_i;
    req_vec[C_DBGF]   = dbg_fault_i;
  end

  assign req_any = |req_vec;
  assign clr_vec = (bus_we_i && (bus_addr_i == ADDR_W'(A_CAUSE)))
                 ? bus_wdata_i[CAUSE_W-1:0] : '0;

  rstsrc_flags #(
    .W       (CAUSE_W),
    .VALID   (VALID),
    .POR_BIT (C_POR)
  ) flags_i (
    .clk     (clk),
    .rst     (rst),
    .set_i   (req_vec),
    .clr_i   (clr_vec),
    .flags_o (cause_q)
  );

  rstsrc_stretch #(
    .HOLD_CYCLES (HOLD_CYCLES)
  ) stretch_i (
    .clk    (clk),
    .rst    (rst),
    .trig_i (req_any),
    .rst_o  (sys_rst_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      case (bus_addr_i)
        ADDR_W'(A_CAUSE): rdata_q <= DATA_W'(cause_q);
        ADDR_W'(A_PDR):   rdata_q <= DATA_W'({cfg.pdr_lvl, cfg.pdr_en});
        ADDR_W'(A_BOR):   rdata_q <= DATA_W'({cfg.bor_lvl, 1'b0, ~cfg.bor_en});
        ADDR_W'(A_LKUP):  rdata_q <= DATA_W'({lk_en, 1'b0});
        default:          rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata_o = rdata_q;
  assign pdr_en_o    = cfg.pdr_en;
  assign pdr_level_o = cfg.pdr_lvl;
  assign bor_en_o    = cfg.bor_en;
  assign bor_level_o = cfg.bor_lvl;

endmodule

// File: rtl/rstsrc_ctrl_chk.sv
module rstsrc_ctrl_chk
  import rstsrc_pkg::*;
#(
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned HOLD_CYCLES = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_we_i,
  input logic [ADDR_W-1:0]  bus_addr_i,
  input logic [DATA_W-1:0]  bus_wdata_i,
  input logic               pin_rst_i,
  input logic               sys_rst_o,
  input logic [CAUSE_W-1:0] cause_q,
  input logic               lk_en,
  input logic               req_any,
  input logic [LVL_W-1:0]   pdr_level_o,
  input logic [LVL_W-1:0]   bor_level_o
);

  localparam int unsigned QW = $clog2(HOLD_CYCLES + 2) + 1;
  localparam logic [CAUSE_W-1:0] POR_ONLY = CAUSE_W'(1) << C_POR;

  logic [QW-1:0] since_q;
  logic          was_por_q;

  // cycles since the last accepted request, saturating past the window
  always_ff @(posedge clk) begin
    if (rst || req_any)                    since_q <= QW'(1);
    else if (since_q <= QW'(HOLD_CYCLES))  since_q <= since_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    was_por_q <= rst;
    if (was_por_q) begin
      assert_por_flags_R1: assert (cause_q == POR_ONLY)
        else $error("cause flags not power-on only after reset");
    end
  end

  assert_hold_len_R9: assert property (@(posedge clk) disable iff (rst)
    sys_rst_o == (since_q <= QW'(HOLD_CYCLES)));

  assert_rst_follows_R9: assert property (@(posedge clk) disable iff (rst)
    req_any |=> sys_rst_o);

  assert_set_wins_R4: assert property (@(posedge clk) disable iff (rst)
    pin_rst_i |=> cause_q[C_PIN]);

  assert_lockup_gate_R6: assert property (@(posedge clk) disable iff (rst)
    (!lk_en && !cause_q[C_LOCKUP]) |=> !cause_q[C_LOCKUP]);

  assert_soft_key_R5: assert property (@(posedge clk) disable iff (rst)
    (!cause_q[C_SOFT] &&
     !(bus_we_i && bus_addr_i == ADDR_W'(A_SOFT) &&
       bus_wdata_i == DATA_W'(SOFT_KEY))) |=> !cause_q[C_SOFT]);

  assert_pdr_stable_R7: assert property (@(posedge clk) disable iff (rst)
    !(bus_we_i && bus_addr_i == ADDR_W'(A_PDR)) |=> $stable(pdr_level_o));

  assert_bor_stable_R8: assert property (@(posedge clk) disable iff (rst)
    !(bus_we_i && bus_addr_i == ADDR_W'(A_BOR)) |=> $stable(bor_level_o));

  assert_flag_survives_R10: assert property (@(posedge clk) disable iff (rst)
    (sys_rst_o && cause_q[C_PIN] &&
     !(bus_we_i && bus_addr_i == ADDR_W'(A_CAUSE))) |=> cause_q[C_PIN]);

endmodule

bind rstsrc_ctrl rstsrc_ctrl_chk #(
  .ADDR_W      (ADDR_W),
  .DATA_W      (DATA_W),
  .HOLD_CYCLES (HOLD_CYCLES)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .pin_rst_i   (pin_rst_i),
  .sys_rst_o   (sys_rst_o),
  .cause_q     (cause_q),
  .lk_en       (lk_en),
  .req_any     (req_any),
  .pdr_level_o (pdr_level_o),
  .bor_level_o (bor_level_o)
);

// File: tb/rstsrc_ctrl_tb_top.sv
`timescale 1ns/1ps
module rstsrc_ctrl_tb_top;

  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;
  localparam int HOLD   = 16;
  localparam logic [31:0] KEY   = 32'h5C5C_AABB;
  localparam logic [31:0] VALID = 32'h0000_1F37;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic [7:0]        ev = '0; // irq,lockup,wwdg,iwdg,pdr,bor,pin,dbg
  logic              sys_rst, pdr_en, bor_en;
  logic [1:0]        pdr_lvl, bor_lvl;

  rstsrc_ctrl dut_i (
    .clk          (clk),
    .rst          (rst),
    .bus_we_i     (bus_we),
    .bus_addr_i   (bus_addr),
    .bus_wdata_i  (bus_wdata),
    .bus_rdata_o  (bus_rdata),
    .irq_sysreq_i (ev[0]),
    .lockup_i     (ev[1]),
    .wwdg_i       (ev[2]),
    .iwdg_i       (ev[3]),
    .pdr_trip_i   (ev[4]),
    .bor_trip_i   (ev[5]),
    .pin_rst_i    (ev[6]),
    .dbg_fault_i  (ev[7]),
    .sys_rst_o    (sys_rst),
    .pdr_en_o     (pdr_en),
    .pdr_level_o  (pdr_lvl),
    .bor_en_o     (bor_en),
    .bor_level_o  (bor_lvl)
  );

  always #4 clk = ~clk;

  // behavioural reference state
  logic [31:0] m_flags, m_rdata;
  bit          m_pdr_en, m_bor_dis, m_lk, m_rst_o;
  int          m_pdr_lvl, m_bor_lvl, m_rem;
  int          compared = 0, mismatched = 0;
  bit          armed = 0, done = 0;
  string       phase = "R1 power-on";

  function automatic logic [31:0] m_read(int a);
    case (a)
      0: return m_flags;
      1: return 32'(m_pdr_lvl * 2 + int'(m_pdr_en));
      2: return 32'(m_bor_lvl * 4 + int'(m_bor_dis));
      3: return m_lk ? 32'h2 : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [31:0] set, clr, rd;
    if (rst) begin
      m_flags = 32'h200; m_pdr_en = 1; m_pdr_lvl = 0;
      m_bor_dis = 0; m_bor_lvl = 0; m_lk = 1;
      m_rem = HOLD; m_rdata = 0;
    end else begin
      rd  = m_read(int'(bus_addr));
      set = 0;
      if (ev[0]) set[0] = 1;
      if (ev[1] && m_lk) set[1] = 1;
      if (ev[2]) set[2] = 1;
      if (ev[3]) set[3+1] = 1;
      if (bus_we && bus_addr == 4 && bus_wdata == KEY) set[5] = 1;
      if (ev[4] && m_pdr_en) set[8] = 1;
      if (ev[5] && !m_bor_dis) set[10] = 1;
      if (ev[6]) set[11] = 1;
      if (ev[7]) set[12] = 1;
      clr = (bus_we && bus_addr == 0) ? (bus_wdata & VALID) : 32'h0;
      m_flags = (m_flags & ~clr) | set;
      if (bus_we && bus_addr == 1) begin
        m_pdr_en = bus_wdata[0]; m_pdr_lvl = int'(bus_wdata[2:1]);
      end
      if (bus_we && bus_addr == 2) begin
        m_bor_dis = bus_wdata[0]; m_bor_lvl = int'(bus_wdata[3:2]);
      end
      if (bus_we && bus_addr == 3) m_lk = bus_wdata[1];
      if (set != 0) m_rem = HOLD;
      else if (m_rem > 0) m_rem--;
      m_rdata = rd;
    end
    m_rst_o = (m_rem > 0);
    armed = 1;
  end

  task automatic chk(string f, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", phase, f, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (armed && !done) begin
      chk("sys_rst_o",   32'(sys_rst), 32'(m_rst_o));
      chk("pdr_en_o",    32'(pdr_en),  32'(m_pdr_en));
      chk("pdr_level_o", 32'(pdr_lvl), 32'(m_pdr_lvl));
      chk("bor_en_o",    32'(bor_en),  32'(!m_bor_dis));
      chk("bor_level_o", 32'(bor_lvl), 32'(m_bor_lvl));
      chk("bus_rdata_o", bus_rdata,    m_rdata);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, logic [31:0] d);
    bus_we = 1; bus_addr = ADDR_W'(a); bus_wdata = d;
    @(negedge clk);
    bus_we = 0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic pulse(logic [7:0] m);
    ev = m;
    @(negedge clk);
    ev = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst = 0;
    idle(20);
    phase = "R11 read map";
    for (int a = 1; a < 8; a++) begin bus_addr = ADDR_W'(a); idle(2); end
    bus_addr = '0;
    phase = "R2 R9 pin";      pulse(8'h40); idle(20);
    phase = "R3 clear";       wr(0, 32'h0); idle(2); wr(0, 32'h800); idle(2);
                              wr(0, 32'h200); idle(2);
    phase = "R4 set wins";
    ev = 8'h40; bus_we = 1; bus_addr = '0; bus_wdata = 32'h800;
    @(negedge clk);
    ev = '0; bus_we = 0; bus_wdata = '0;
    idle(20);
    phase = "R5 soft key";    wr(4, KEY ^ 32'h1); idle(3); wr(4, 32'h0); idle(3);
                              wr(4, KEY); idle(20);
    bus_addr = 3'd4; idle(2); bus_addr = '0;
    phase = "R6 lockup";      wr(3, 32'h0); pulse(8'h02); idle(20);
                              wr(3, 32'h2); pulse(8'h02); idle(20);
    phase = "R7 power-down";  wr(1, 32'h6); pulse(8'h10); idle(20);
                              wr(1, 32'h5); pulse(8'h10); idle(20);
    phase = "R8 brown-out";   wr(2, 32'h9); pulse(8'h20); idle(20);
                              wr(2, 32'hE); bus_addr = 3'd2; idle(2);
                              bus_addr = '0; pulse(8'h20); idle(20);
    phase = "R9 retrigger";   pulse(8'h04); idle(8); pulse(8'h08); idle(20);
    phase = "R2 sources";     pulse(8'h01); idle(20); pulse(8'h80); idle(20);
                              pulse(8'hFF); idle(20);
    phase = "R10 keep";       pulse(8'h40); idle(5); wr(5, 32'hFFFF_FFFF);
                              wr(7, 32'hFFFF_FFFF); idle(20);
                              bus_addr = 3'd1; idle(2); bus_addr = 3'd3; idle(2);
                              bus_addr = '0;
    phase = "R3 clear all";   wr(0, 32'hFFFF_FFFF); idle(3);
    phase = "R1 second power-on";
    rst = 1; idle(3); rst = 0; idle(20);
    for (int a = 0; a < 4; a++) begin bus_addr = ADDR_W'(a); idle(2); end
    finish_run();
  end

endmodule